// File: doc/BRIEF.md
# Receive Word DMA Channel

This block is a single DMA channel that moves one received packet from a peripheral's word-wide receive data register into system memory. Software loads a source selector, a destination address and a packet length in bytes while the channel is idle. It then sets the run bit. While running, the channel pops one 16-bit word each cycle the peripheral reports a word is ready. It writes that word to the current destination address through a synchronous word-write port and advances the address.

The channel handles whole words only. A length written with an odd byte count is rounded up to the next even count. When the remaining count reaches zero, the run bit clears by itself and a sticky done flag is raised. Software clears that flag by writing a one to it. Clearing the run bit by hand stops the channel after the current cycle, without the done flag. The address and count reached so far are kept, so the channel must be stopped before the receive FIFO behind the peripheral is flushed. Every new packet needs the pointers, the length and the run bit loaded again.

Top module: `dma_rx_word_chan`

## Requirements
- R1: After reset every register reads zero, busy_o and irq_o are low, and neither per_rd_o nor mem_we_o is asserted.
- R2: The register at address 1 (source selector), address 2 (destination) and address 3 (length in bytes) accept writes while the channel is idle and read back the written value. An odd length reads back rounded up to the next even value.
- R3: Writing a value with bit 0 set to address 0 starts the channel. busy_o and address 0 bit 0 read high from the next cycle.
- R4: In a cycle where the channel runs, the remaining length is nonzero and per_ready_i is high, per_rd_o and mem_we_o are high, mem_addr_o is the current destination and mem_wdata_o equals per_data_i. After that edge the destination has grown by 2 and the remaining length has shrunk by 2.
- R5: While per_ready_i is low no word is read or written, and the destination and remaining length hold.
- R6: One cycle after the remaining length reaches zero while running, busy_o falls and the done flag (address 4 bit 0, mirrored on irq_o) is set. A start with a length of zero completes one cycle after the start.
- R7: Writing 1 to address 4 bit 0 clears the done flag, and writing 0 there leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: Writing a value with bit 0 clear to address 0 while running stops the channel after that cycle. No done flag is raised, no further words are read, and the destination and remaining length keep their reached values. A later start resumes from them.
- R9: Writes to addresses 1, 2 and 3 are ignored while the channel runs.
- R10: per_sel_o always presents the source selector register.
- R11: Once a packet has completed, per_ready_i causes no reads until the channel is started again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address for write and read |
| cfg_wdata_i | input | ADDR_W | Register write data |
| cfg_rdata_o | output | ADDR_W | Register read data (combinational) |
| per_ready_i | input | 1 | Peripheral has a received word ready |
| per_data_i | input | 16 | Received word from the peripheral |
| per_rd_o | output | 1 | Pop the ready word this cycle |
| per_sel_o | output | ADDR_W | Source selector for the peripheral register |
| mem_we_o | output | 1 | Memory word write enable |
| mem_addr_o | output | ADDR_W | Memory byte address of the word |
| mem_wdata_o | output | 16 | Memory write data |
| busy_o | output | 1 | Channel is running |
| irq_o | output | 1 | Sticky done flag |

## Verification
The bound checker watches properties that must hold on every cycle. A pop happens only when a word is ready and the channel is running with bytes left. Each pop advances the destination by exactly two. The remaining count never turns odd. The done flag rises only right after a run has emptied its count. A run ending without the flag must follow a write that cleared the run bit. Only the directed scenarios can show the rest: exact data ordering under stalls, odd-length rounding, a zero-length start, register read-back and ignored writes while busy, write-one-to-clear precedence, and resuming after a manual stop.

// File: rtl/dma_rx_pkg.sv
package dma_rx_pkg;
  localparam int WORD_W     = 16;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int REG_AW     = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL = 3'd0,
    REG_SRC  = 3'd1,
    REG_DST  = 3'd2,
    REG_LEN  = 3'd3,
    REG_STAT = 3'd4
  } reg_e;
endpackage

// File: rtl/dma_rx_cfg.sv
module dma_rx_cfg
  import dma_rx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              run_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [LEN_W-1:0]  rem_i,
  input  logic              irq_i,
  output logic              ctrl_we_o,
  output logic              src_we_o,
  output logic              dst_we_o,
  output logic              len_we_o,
  output logic              stat_we_o,
  output logic [ADDR_W-1:0] rdata_o
);
  always_comb begin
    ctrl_we_o = 1'b0;
    src_we_o  = 1'b0;
    dst_we_o  = 1'b0;
    len_we_o  = 1'b0;
    stat_we_o = 1'b0;
    case (addr_i)
      REG_CTRL: ctrl_we_o = we_i;
      REG_SRC:  src_we_o  = we_i;
      REG_DST:  dst_we_o  = we_i;
      REG_LEN:  len_we_o  = we_i;
      REG_STAT: stat_we_o = we_i;
      default: ;
    endcase
  end

  always_comb begin
    case (addr_i)
      REG_CTRL: rdata_o = ADDR_W'(run_i);
      REG_SRC:  rdata_o = src_i;
      REG_DST:  rdata_o = dst_i;
      REG_LEN:  rdata_o = ADDR_W'(rem_i);
      REG_STAT: rdata_o = ADDR_W'(irq_i);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_rx_engine.sv
module dma_rx_engine
  import dma_rx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              src_we_i,
  input  logic              dst_we_i,
  input  logic              len_we_i,
  input  logic              stat_we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              ready_i,
  output logic              xfer_o,
  output logic              run_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [LEN_W-1:0]  rem_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);
  localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(WORD_BYTES);

  logic              run_q, irq_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  rem_q;
  logic [LEN_W-1:0]  len_rnd;
  logic              done;

  // odd byte counts round up to a whole word
  assign len_rnd = {wdata_i[LEN_W-1:1] + (LEN_W-1)'(wdata_i[0]), 1'b0};
  assign done    = run_q && (rem_q == '0);
  assign xfer_o  = run_q && (rem_q != '0) && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      irq_q <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
    end else begin
      if (done)           run_q <= 1'b0;
      else if (ctrl_we_i) run_q <= wdata_i[0];

      if (done)                        irq_q <= 1'b1;
      else if (stat_we_i && wdata_i[0]) irq_q <= 1'b0;

      if (src_we_i && !run_q) src_q <= wdata_i;

      if (xfer_o)                  dst_q <= dst_q + ADDR_STEP;
      else if (dst_we_i && !run_q) dst_q <= wdata_i;

      if (xfer_o)                  rem_q <= rem_q - LEN_STEP;
      else if (len_we_i && !run_q) rem_q <= len_rnd;
    end
  end

  assign run_o = run_q;
  assign src_o = src_q;
  assign dst_o = dst_q;
  assign rem_o = rem_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/dma_rx_word_chan.sv
module dma_rx_word_chan
  import dma_rx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic [ADDR_W-1:0] cfg_rdata_o,
  input  logic              per_ready_i,
  input  logic [15:0]       per_data_i,
  output logic              per_rd_o,
  output logic [ADDR_W-1:0] per_sel_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  output logic              busy_o,
  output logic              irq_o
);
  logic              ctrl_we, src_we, dst_we, len_we, stat_we;
  logic              xfer, run;
  logic [ADDR_W-1:0] src, dst;
  logic [LEN_W-1:0]  rem_bytes;
  logic              irq;

  dma_rx_cfg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cfg (
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .run_i    (run),
    .src_i    (src),
    .dst_i    (dst),
    .rem_i    (rem_bytes),
    .irq_i    (irq),
    .ctrl_we_o(ctrl_we),
    .src_we_o (src_we),
    .dst_we_o (dst_we),
    .len_we_o (len_we),
    .stat_we_o(stat_we),
    .rdata_o  (cfg_rdata_o)
  );

  dma_rx_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_we_i(ctrl_we),
    .src_we_i (src_we),
    .dst_we_i (dst_we),
    .len_we_i (len_we),
    .stat_we_i(stat_we),
    .wdata_i  (cfg_wdata_i),
    .ready_i  (per_ready_i),
    .xfer_o   (xfer),
    .run_o    (run),
    .src_o    (src),
    .dst_o    (dst),
    .rem_o    (rem_bytes),
    .irq_o    (irq)
  );

  // word goes straight from the peripheral to the write port
  assign per_rd_o    = xfer;
  assign mem_we_o    = xfer;
  assign mem_addr_o  = dst;
  assign mem_wdata_o = per_data_i;
  assign per_sel_o   = src;
  assign busy_o      = run;
  assign irq_o       = irq;
endmodule

// File: rtl/dma_rx_word_chan_chk.sv
module dma_rx_word_chan_chk #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [2:0]        cfg_addr_i,
  input logic              cfg_bit0_i,
  input logic              per_ready_i,
  input logic              per_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy_o,
  input logic              irq_o,
  input logic [LEN_W-1:0]  rem_i
);
  a_r5_no_pop_unready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_ready_i |-> !per_rd_o);

  a_r4_pop_needs_work: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_rd_o |-> busy_o && (rem_i != '0));

  a_r4_dst_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_rd_o |=> mem_addr_o == $past(mem_addr_o) + ADDR_W'(2));

  a_r2_rem_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_i[0] == 1'b0);

  a_r6_irq_after_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(busy_o) && ($past(rem_i) == '0));

  a_r8_stop_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !irq_o) |-> $past(cfg_we_i && (cfg_addr_i == 3'd0) && !cfg_bit0_i));
endmodule

bind dma_rx_word_chan dma_rx_word_chan_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .cfg_bit0_i (cfg_wdata_i[0]),
  .per_ready_i(per_ready_i),
  .per_rd_o   (per_rd_o),
  .mem_addr_o (mem_addr_o),
  .busy_o     (busy_o),
  .irq_o      (irq_o),
  .rem_i      (rem_bytes)
);

// File: tb/dma_rx_word_chan_tb.sv
module dma_rx_word_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int WD_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic          per_ready = 1'b0;
  logic [15:0]   per_data = '0;
  logic          per_rd;
  logic [AW-1:0] per_sel;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic          busy, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_rx_word_chan #(.ADDR_W(AW), .LEN_W(12)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .per_ready_i(per_ready), .per_data_i(per_data), .per_rd_o(per_rd), .per_sel_o(per_sel),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .busy_o(busy), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = AW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    cfg_addr = 3'(a);
    #1;
    chk(cfg_rdata == AW'(exp), req, int'(cfg_rdata), exp);
  endtask

  // peripheral model; mode 0 = always ready, 1 = stalls
  task automatic pump(input int words, input int dst0, input int mode, input int seed);
    int got = 0;
    int cyc = 0;
    while (got < words && cyc < 200) begin
      per_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      per_data  = 16'(seed + got * 16'h0111);
      #1;
      if (per_ready) begin
        chk(per_rd && mem_we, "R4 pop", int'({per_rd, mem_we}), 3);
        chk(mem_addr == AW'(dst0 + 2*got), "R4 addr", int'(mem_addr), dst0 + 2*got);
        chk(mem_wdata == per_data, "R4 data", int'(mem_wdata), int'(per_data));
        got++;
      end else begin
        chk(!per_rd && !mem_we, "R5 stall", int'({per_rd, mem_we}), 0);
        chk(mem_addr == AW'(dst0 + 2*got), "R5 hold", int'(mem_addr), dst0 + 2*got);
      end
      cyc++;
      @(negedge clk);
    end
    per_ready = 1'b0;
  endtask

  task automatic expect_done(input string tag);
    chk(busy && !irq, {tag, " R6 last cycle"}, int'({busy, irq}), 2);
    @(negedge clk);
    chk(!busy && irq, {tag, " R6 done"}, int'({busy, irq}), 1);
    rd_chk(4, 1, {tag, " R6 stat"});
    rd_chk(0, 0, {tag, " R6 ctrl"});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !irq && !per_rd && !mem_we, "R1 outputs", int'({busy, irq, per_rd, mem_we}), 0);
    for (int a = 0; a < 5; a++) rd_chk(a, 0, "R1 regs");
  endtask

  task automatic t_program();
    wr(1, 16'h0042); wr(2, 16'h1000); wr(3, 5);
    rd_chk(1, 16'h0042, "R2 src");
    rd_chk(2, 16'h1000, "R2 dst");
    rd_chk(3, 6, "R2 odd rounds up");
    chk(per_sel == 16'h0042, "R10 sel", int'(per_sel), 16'h0042);
  endtask

  task automatic t_basic();
    wr(3, 6);
    wr(0, 1);
    chk(busy, "R3 busy", int'(busy), 1);
    rd_chk(0, 1, "R3 ctrl");
    pump(3, 16'h1000, 0, 16'h1234);
    expect_done("basic");
    rd_chk(2, 16'h1006, "R4 dst end");
    per_ready = 1'b1; #1;
    chk(!per_rd && !mem_we, "R11 no pop after done", int'(per_rd), 0);
    @(negedge clk); per_ready = 1'b0;
    wr(4, 0);
    chk(irq, "R7 write 0 keeps", int'(irq), 1);
    wr(4, 1);
    chk(!irq, "R7 w1c", int'(irq), 0);
  endtask

  task automatic t_stall_odd();
    wr(2, 16'h2000); wr(3, 9);
    wr(0, 1);
    wr(2, 16'h0999); wr(3, 16'h0020); wr(1, 16'h0077);
    rd_chk(2, 16'h2000, "R9 dst ignored");
    rd_chk(3, 10, "R9 len ignored");
    rd_chk(1, 16'h0042, "R9 src ignored");
    pump(5, 16'h2000, 1, 16'hBEEF);
    expect_done("stall");
    wr(4, 1);
  endtask

  task automatic t_zero();
    wr(3, 0);
    wr(0, 1);
    expect_done("zero");
  endtask

  task automatic t_stop();
    wr(4, 1);
    wr(2, 16'h3000); wr(3, 8);
    wr(0, 1);
    pump(2, 16'h3000, 0, 16'h5500);
    wr(0, 0);
    chk(!busy && !irq, "R8 stopped no irq", int'({busy, irq}), 0);
    rd_chk(3, 4, "R8 len kept");
    rd_chk(2, 16'h3004, "R8 dst kept");
    per_ready = 1'b1; #1;
    chk(!per_rd, "R8 no pop", int'(per_rd), 0);
    @(negedge clk); per_ready = 1'b0;
    wr(0, 1);
    pump(2, 16'h3004, 0, 16'h6600);
    expect_done("resume");
  endtask

  task automatic t_set_wins();
    wr(4, 1);
    wr(3, 2);
    wr(0, 1);
    pump(1, 16'h3008, 0, 16'h7000);
    cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 16'd1;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(irq, "R7 set beats clear", int'(irq), 1);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_basic();
    t_stall_odd();
    t_zero();
    t_stop();
    t_set_wins();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule